// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one timer channel driven through a small word-addressed register bus. Software programs a start value into a reload register, then writes a control word that holds an enable flag, a free-run (periodic) flag and an eight-bit clock divider stored as the division ratio minus one. While the channel is enabled, the divider turns the input clock into ticks, and each tick lowers a 24-bit counter by one.

When a tick finds the counter at one or zero, the counter has expired. In periodic mode it then reloads from the reload register and carries on, so the channel runs freely. In single-pass mode it settles at zero and the hardware clears the enable flag. Every expiry produces a one-cycle pulse on a dedicated output.

The usual bring-up sequence is:
- write zero to the control word;
- load 0xFFFFFF into the reload register;
- enable periodic mode with a divider of 24, which gives 1 MHz ticks from a 25 MHz clock.

Top module: `dtimer_channel`

## Requirements
- R1: After reset, reads at byte offsets 0x00, 0x08 and 0x10 return zero, and the expiry output is low.
- R2: The register map and its read-back rules are as follows.
  - The control word is at 0x00. Bit 30 is the enable, bit 27 is the periodic flag and bits 7:0 are the divider. Every other bit reads zero.
  - The reload register is at 0x08. It keeps bits 23:0 of a write and reads back zero-extended.
  - The live count is at 0x10. It reads as bits 23:0 with the upper bits zero.
  - Any other offset reads zero, and a write to it is ignored.
- R3: Writing the control word with bit 30 set while the channel is disabled loads the counter from the reload register at that clock edge and restarts the divider.
- R4: With divider value P, the counter drops by one every P+1 clocks while enabled. The first drop happens at the (P+1)th edge after the enabling write.
- R5: In periodic mode, a tick that finds the count at 1 or 0 loads the reload value, and the channel stays enabled.
- R6: In single-pass mode, a tick that finds the count at 1 or 0 sets the count to 0 and clears the enable bit, as seen when reading the control word. The count then stays at 0.
- R7: The expiry output is high for exactly the one clock that follows each edge at which an expiring tick is taken. When ticks expire on consecutive edges, the output stays high across those clocks.
- R8: Writing the control word with bit 30 clear freezes the count at its present value. A later enabling write reloads the counter from the reload register.
- R9: Two kinds of write leave the count untouched, so it keeps following its tick sequence:
  - a write to offset 0x10;
  - a control write with bit 30 set while the channel is already enabled, which neither reloads the counter nor restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 5 | Byte offset of the register being accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| expire | output | 1 | One-clock pulse after each expiry |

## Verification
The assertions assume that a write is presented for one clock with a stable address and data. They also assume that the enable bit changes only through a control write or a single-pass expiry, so nothing else may disturb the control word between the clocks they compare. The bench drives every input on the falling edge, holds each write for exactly one rising edge and returns the address to the count register between accesses. Its randomised phase uses small divider and reload values, so that expiries, reloads and stops happen many times while the same input discipline is kept.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  localparam int DTM_DATA_W = 32;
  localparam int DTM_ADDR_W = 5;
  localparam int DTM_CNT_W  = 24;
  localparam int DTM_PSC_W  = 8;

  // Bit positions inside the control word; software relies on them.
  localparam int DTM_EN_BIT  = 30;
  localparam int DTM_PER_BIT = 27;

  // Byte offsets of the three registers.
  localparam int DTM_OFF_CTRL = 'h00;
  localparam int DTM_OFF_INIT = 'h08;
  localparam int DTM_OFF_DATA = 'h10;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_INIT = 2'd2,
    SEL_DATA = 2'd3
  } dtm_sel_e;

endpackage

// File: rtl/dtm_regs.sv
module dtm_regs
  import dtm_pkg::*;
#(
  parameter int DATA_W  = DTM_DATA_W,
  parameter int ADDR_W  = DTM_ADDR_W,
  parameter int CNT_W   = DTM_CNT_W,
  parameter int PSC_W   = DTM_PSC_W,
  parameter int EN_BIT  = DTM_EN_BIT,
  parameter int PER_BIT = DTM_PER_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              stop_i,
  output logic [DATA_W-1:0] rdata,
  output logic              en_o,
  output logic              per_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CNT_W-1:0]  init_o,
  output logic              start_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(DTM_OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(DTM_OFF_INIT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DTM_OFF_DATA);

  dtm_sel_e sel;

  logic             wr_ctrl;
  logic             wr_init;
  logic             ctrl_ce;
  logic             en_q,   en_d;
  logic             per_q,  per_d;
  logic [PSC_W-1:0] psc_q,  psc_d;
  logic [CNT_W-1:0] init_q, init_d;

  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] init_word;
  logic [DATA_W-1:0] data_word;

  // Address decode
  always_comb begin
    if (addr == A_CTRL) begin
      sel = SEL_CTRL;
    end else if (addr == A_INIT) begin
      sel = SEL_INIT;
    end else if (addr == A_DATA) begin
      sel = SEL_DATA;
    end else begin
      sel = SEL_NONE;
    end
  end

  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign wr_init = wr_en && (sel == SEL_INIT);

  // Next state: a bus write takes priority over the hardware stop
  always_comb begin
    en_d   = en_q;
    per_d  = per_q;
    psc_d  = psc_q;
    init_d = init_q;
    if (wr_ctrl) begin
      en_d  = wdata[EN_BIT];
      per_d = wdata[PER_BIT];
      psc_d = wdata[PSC_W-1:0];
    end else if (stop_i) begin
      en_d = 1'b0;
    end
    if (wr_init) begin
      init_d = wdata[CNT_W-1:0];
    end
  end

  assign ctrl_ce = wr_ctrl || stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      per_q <= 1'b0;
      psc_q <= '0;
    end else if (ctrl_ce) begin
      en_q  <= en_d;
      per_q <= per_d;
      psc_q <= psc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
    end else if (wr_init) begin
      init_q <= init_d;
    end
  end

  // A rising enable is a start
  assign start_o = wr_ctrl && wdata[EN_BIT] && !en_q;

  // Read path
  always_comb begin
    ctrl_word                = '0;
    ctrl_word[EN_BIT]        = en_q;
    ctrl_word[PER_BIT]       = per_q;
    ctrl_word[PSC_W-1:0]     = psc_q;
  end

  generate
    if (DATA_W > CNT_W) begin : g_zext
      assign init_word = {{(DATA_W-CNT_W){1'b0}}, init_q};
      assign data_word = {{(DATA_W-CNT_W){1'b0}}, count_i};
    end else begin : g_flat
      assign init_word = init_q[DATA_W-1:0];
      assign data_word = count_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata = ctrl_word;
      SEL_INIT: rdata = init_word;
      SEL_DATA: rdata = data_word;
      default:  rdata = '0;
    endcase
  end

  assign en_o   = en_q;
  assign per_o  = per_q;
  assign psc_o  = psc_q;
  assign init_o = init_q;

endmodule

// File: rtl/dtm_prescale.sv
module dtm_prescale
  import dtm_pkg::*;
#(
  parameter int PSC_W = DTM_PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] pc_q, pc_d;
  logic             pc_ce;

  // The >= compare also covers a divider lowered below the running phase
  assign tick_o = en_i && (pc_q >= psc_i);

  always_comb begin
    if (start_i || tick_o) begin
      pc_d = '0;
    end else begin
      pc_d = pc_q + PSC_W'(1);
    end
  end

  assign pc_ce = start_i || en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_ce) begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/dtm_count.sv
module dtm_count
  import dtm_pkg::*;
#(
  parameter int CNT_W = DTM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             per_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o,
  output logic             stop_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             at_end;
  logic             exp_evt;
  logic             expire_q;

  assign at_end  = (cnt_q <= CNT_W'(1));
  assign exp_evt = tick_i && at_end;
  assign stop_o  = exp_evt && !per_i;

  always_comb begin
    if (start_i) begin
      cnt_d = init_i;
    end else if (exp_evt) begin
      cnt_d = per_i ? init_i : '0;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  assign cnt_ce = start_i || tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expire_q <= 1'b0;
    end else begin
      expire_q <= exp_evt;
    end
  end

  assign count_o  = cnt_q;
  assign expire_o = expire_q;

endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel
  import dtm_pkg::*;
#(
  parameter int DATA_W  = DTM_DATA_W,
  parameter int ADDR_W  = DTM_ADDR_W,
  parameter int CNT_W   = DTM_CNT_W,
  parameter int PSC_W   = DTM_PSC_W,
  parameter int EN_BIT  = DTM_EN_BIT,
  parameter int PER_BIT = DTM_PER_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              expire
);

  logic             ctrl_en;
  logic             ctrl_per;
  logic [PSC_W-1:0] ctrl_psc;
  logic [CNT_W-1:0] init_val;
  logic [CNT_W-1:0] cnt_val;
  logic             start;
  logic             stop;
  logic             tick;

  dtm_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .PSC_W  (PSC_W),
    .EN_BIT (EN_BIT),
    .PER_BIT(PER_BIT)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .count_i(cnt_val),
    .stop_i (stop),
    .rdata  (rdata),
    .en_o   (ctrl_en),
    .per_o  (ctrl_per),
    .psc_o  (ctrl_psc),
    .init_o (init_val),
    .start_o(start)
  );

  dtm_prescale #(
    .PSC_W(PSC_W)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ctrl_en),
    .start_i(start),
    .psc_i  (ctrl_psc),
    .tick_o (tick)
  );

  dtm_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .tick_i  (tick),
    .per_i   (ctrl_per),
    .init_i  (init_val),
    .count_o (cnt_val),
    .expire_o(expire),
    .stop_o  (stop)
  );

endmodule

// File: rtl/dtimer_channel_chk.sv
module dtimer_channel_chk
  import dtm_pkg::*;
#(
  parameter int DATA_W  = DTM_DATA_W,
  parameter int ADDR_W  = DTM_ADDR_W,
  parameter int CNT_W   = DTM_CNT_W,
  parameter int EN_BIT  = DTM_EN_BIT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              expire,
  input logic              en,
  input logic              per,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  init,
  input logic              tick
);

  logic wr_ctrl_c;
  logic start_c;
  logic end_tick;

  assign wr_ctrl_c = wr_en && (addr == ADDR_W'(DTM_OFF_CTRL));
  assign start_c   = wr_ctrl_c && wdata[EN_BIT] && !en;
  assign end_tick  = tick && (count <= CNT_W'(1));

  a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (count == $past(init)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (count > CNT_W'(1))) |=> (count == $past(count) - CNT_W'(1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start_c) |=> (count == $past(count)));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (end_tick && per) |=> (count == $past(init)));

  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (end_tick && !per && !wr_ctrl_c) |=> (!en && (count == '0)));

  a_r7_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
    end_tick |=> expire);

  a_r7_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    !end_tick |=> !expire);

  a_r8_no_self_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_ctrl_c) |=> !en);

  a_r4_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);

endmodule

bind dtimer_channel dtimer_channel_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .EN_BIT(EN_BIT)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .expire(expire),
  .en    (ctrl_en),
  .per   (ctrl_per),
  .count (cnt_val),
  .init  (init_val),
  .tick  (tick)
);

// File: tb/tb_dtimer_channel.sv
module tb_dtimer_channel;

  localparam int CLK_P = 10;
  localparam int WDOG  = 200000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        expire;

  int    n_chk;
  int    n_bad;
  bit    done;
  bit    cmp_on;
  string cur_req;

  dtimer_channel dut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .expire(expire)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference model
  bit          m_en, m_per, m_exp;
  int          m_psc, m_pc;
  logic [23:0] m_init, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_exp = 0;
      m_psc = 0; m_pc = 0; m_init = '0; m_cnt = '0;
    end else begin
      bit wc, wi, st, tk, ex;
      wc = wr_en && (addr == 5'h00);
      wi = wr_en && (addr == 5'h08);
      st = wc && wdata[30] && !m_en;
      tk = m_en && (m_pc >= m_psc);
      ex = tk && (m_cnt <= 24'd1);
      m_exp = ex;
      if (st) m_cnt = m_init;
      else if (ex) m_cnt = m_per ? m_init : 24'd0;
      else if (tk) m_cnt = m_cnt - 24'd1;
      if (st || tk) m_pc = 0;
      else if (m_en) m_pc = m_pc + 1;
      if (wc) begin
        m_en = wdata[30]; m_per = wdata[27]; m_psc = int'(wdata[7:0]);
      end else if (ex && !m_per) begin
        m_en = 0;
      end
      if (wi) m_init = wdata[23:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      5'h00: begin v[30] = m_en; v[27] = m_per; v[7:0] = 8'(m_psc); end
      5'h08: v[23:0] = m_init;
      5'h10: v[23:0] = m_cnt;
      default: v = '0;
    endcase
    return v;
  endfunction

  // Per-cycle comparison, late in the low phase when inputs are settled
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (cmp_on && rst_n) begin
      n_chk++;
      if (rdata !== m_read(addr) || expire !== m_exp) begin
        n_bad++;
        $display("FAIL %s model @%0t: rdata=%h expire=%b expected rdata=%h expire=%b",
                 cur_req, $time, rdata, expire, m_read(addr), m_exp);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
    addr = 5'h10;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 5'h10; wdata = '0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < WDOG; i++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0; cmp_on = 0; cur_req = "R1";
    rst_n = 1'b0; wr_en = 1'b0; addr = 5'h10; wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    cmp_on = 1;

    // R1 reset state
    rd_chk("R1", 5'h00, 32'h0);
    rd_chk("R1", 5'h08, 32'h0);
    rd_chk("R1", 5'h10, 32'h0);
    chk("R1 expire", {31'b0, expire}, 32'h0);

    // R2 register map
    cur_req = "R2";
    bus_wr(5'h00, 32'h8F0000A5);
    rd_chk("R2 ctrl", 5'h00, 32'h080000A5);
    bus_wr(5'h08, 32'hAB123456);
    rd_chk("R2 init", 5'h08, 32'h00123456);
    rd_chk("R2 data", 5'h10, 32'h0);
    bus_wr(5'h04, 32'hFFFFFFFF);
    rd_chk("R2 unmapped", 5'h04, 32'h0);
    rd_chk("R2 unmapped", 5'h18, 32'h0);
    bus_wr(5'h00, 32'h0);

    // R3 start load, R4 divider timing with P=2
    cur_req = "R4";
    bus_wr(5'h08, 32'd5);
    bus_wr(5'h00, 32'h40000002);
    rd_chk("R3 load", 5'h10, 32'd5);
    step(2);
    rd_chk("R4 before tick", 5'h10, 32'd5);
    step(1);
    rd_chk("R4 first step", 5'h10, 32'd4);
    step(3);
    rd_chk("R4 second step", 5'h10, 32'd3);

    // R8 freeze and reload on re-enable
    cur_req = "R8";
    bus_wr(5'h00, 32'h00000002);
    step(5);
    rd_chk("R8 frozen", 5'h10, 32'd3);
    rd_chk("R8 ctrl", 5'h00, 32'h00000002);
    bus_wr(5'h00, 32'h40000002);
    rd_chk("R8 reload", 5'h10, 32'd5);
    bus_wr(5'h00, 32'h0);

    // R6 single pass, R7 pulse
    cur_req = "R6";
    bus_wr(5'h08, 32'd3);
    bus_wr(5'h00, 32'h40000000);
    rd_chk("R6 load", 5'h10, 32'd3);
    step(1); rd_chk("R6 count", 5'h10, 32'd2);
    step(1); rd_chk("R6 count", 5'h10, 32'd1);
    step(1);
    rd_chk("R6 end", 5'h10, 32'd0);
    rd_chk("R6 enable cleared", 5'h00, 32'h0);
    chk("R7 pulse high", {31'b0, expire}, 32'h1);
    step(1);
    chk("R7 pulse low", {31'b0, expire}, 32'h0);
    step(3);
    rd_chk("R6 stays", 5'h10, 32'd0);

    // R5 periodic reload with P=1
    cur_req = "R5";
    bus_wr(5'h08, 32'd2);
    bus_wr(5'h00, 32'h48000001);
    step(2); rd_chk("R5 count", 5'h10, 32'd1);
    step(2);
    rd_chk("R5 reload", 5'h10, 32'd2);
    chk("R7 periodic pulse", {31'b0, expire}, 32'h1);
    step(1);
    chk("R7 pulse ends", {31'b0, expire}, 32'h0);
    rd_chk("R5 still enabled", 5'h00, 32'h48000001);
    step(3);
    chk("R7 second pulse", {31'b0, expire}, 32'h1);
    step(20);
    bus_wr(5'h00, 32'h0);

    // R7 back-to-back expiries with zero reload and P=0
    cur_req = "R7";
    bus_wr(5'h08, 32'd0);
    bus_wr(5'h00, 32'h48000000);
    step(1); chk("R7 back-to-back", {31'b0, expire}, 32'h1);
    step(1); chk("R7 back-to-back", {31'b0, expire}, 32'h1);
    bus_wr(5'h00, 32'h0);
    step(1);

    // R9 writes that must not disturb the count
    cur_req = "R9";
    bus_wr(5'h08, 32'h100);
    bus_wr(5'h00, 32'h40000000);
    rd_chk("R9 load", 5'h10, 32'h100);
    bus_wr(5'h00, 32'h40000000);
    rd_chk("R9 no reload", 5'h10, 32'hFF);
    bus_wr(5'h10, 32'h12345);
    rd_chk("R9 data write ignored", 5'h10, 32'hFE);
    bus_wr(5'h00, 32'h0);

    // R4 full-range start with divide-by-25
    cur_req = "R4";
    bus_wr(5'h08, 32'h00FFFFFF);
    bus_wr(5'h00, 32'h48000018);
    rd_chk("R4 max load", 5'h10, 32'h00FFFFFF);
    step(24);
    rd_chk("R4 max hold", 5'h10, 32'h00FFFFFF);
    step(1);
    rd_chk("R4 max step", 5'h10, 32'h00FFFFFE);
    bus_wr(5'h00, 32'h48000002);
    step(10);
    bus_wr(5'h00, 32'h0);

    // Mixed traffic checked against the model every clock
    cur_req = "R5/R6/R9 mixed";
    for (int i = 0; i < 600; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0: bus_wr(5'h08, 32'($urandom_range(0, 6)));
        1: bus_wr(5'h00, {1'b0, 1'($urandom_range(0, 1)), 2'b0,
                          1'($urandom_range(0, 1)), 19'b0, 8'($urandom_range(0, 3))});
        2: bus_wr(5'h10, $urandom);
        3: bus_wr(5'h04, $urandom);
        default: step(1);
      endcase
    end

    cmp_on = 0;
    step(2);
    finish_run();
  end

endmodule